// File: doc/BRIEF.md
# Gated Self-Synchronous Payload Scrambler Pair

This block holds a matched transmit scrambler and receive descrambler for the payload area of a generic framing procedure channel. Both use the self-synchronous polynomial x^43 + 1. Each side takes one octet per valid cycle and handles its bits most significant bit first, which is network order. A registered octet leaves each side one cycle later, with its own valid strobe.

A payload gate switches each side on only for payload octets. Header and check octets pass through unchanged. Between payload octets the 43-bit history is frozen, so the payload of each frame continues from the last payload bits of the frame before it. The receive side also takes an in-sync flag from the frame delineator. While that flag is low, the descrambler passes octets through untouched and leaves its history alone. Header generation and delineation are done outside this block.

Top module: `gfp_payload_scrambler`

## Requirements
- R1: For a valid payload octet, the transmit side handles bits 7 down to 0 in turn. Each output bit is the input bit XOR the output bit produced 43 bit positions earlier, and that output bit then enters the history.
- R2: For a valid payload octet while in sync, the receive side handles bits 7 down to 0 in turn. Each output bit is the received bit XOR the received bit 43 positions earlier, and the received bit then enters the history.
- R3: A valid octet with the payload gate low leaves that side unchanged on the next cycle and does not alter its history.
- R4: Cycles with valid low, and non-payload octets, do not alter either history. The first payload octet of a new frame therefore continues the recurrence from the previous frame's last 43 payload bits.
- R5: While the in-sync input is low, the receive side passes every valid octet through unchanged and does not update its history, even when the payload gate is high.
- R6: Each output valid is the matching input valid delayed by exactly one clock. Output data appear on that same cycle.
- R7: Synchronous active-high reset clears both histories and both output valids. After reset, the first 43 payload bits leave the transmit side equal to the input.
- R8: A receive side fed in step with the transmit side's output, with the same payload gating and with in-sync high, reproduces the original transmit input octet for octet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 8 | Octet to scramble |
| tx_valid | input | 1 | tx_data carries an octet this cycle |
| tx_payload | input | 1 | Octet belongs to the payload area |
| tx_out | output | 8 | Scrambled or passed-through octet |
| tx_out_valid | output | 1 | tx_out is valid |
| rx_data | input | 8 | Received octet to descramble |
| rx_valid | input | 1 | rx_data carries an octet this cycle |
| rx_payload | input | 1 | Octet belongs to the payload area |
| rx_in_sync | input | 1 | Delineator reports the sync state |
| rx_out | output | 8 | Descrambled or passed-through octet |
| rx_out_valid | output | 1 | rx_out is valid |

## Verification
A corrupted history bit shows up at the ports only when it reaches the tap. It then flips one output bit 43 bit positions later, which is five or six payload octets after the fault. On the transmit side it keeps recurring every 43 bits after that. A history that is wrongly cleared or advanced on gaps, on header octets or while out of sync shows up in the first octets of the next frame. For that reason the stimulus runs several frames back to back, with idle cycles and header octets between them, and a stretch out of sync before the receive side is resumed.

// File: rtl/gfp_sss_pkg.sv
package gfp_sss_pkg;

    localparam int SSS_TAP    = 43;
    localparam int SSS_OCTET  = 8;

    typedef enum logic {
        SSS_SCRAMBLE   = 1'b0,
        SSS_DESCRAMBLE = 1'b1
    } sss_dir_e;

    typedef struct packed {
        logic                 valid;
        logic [SSS_OCTET-1:0] octet;
    } sss_beat_t;

endpackage

// File: rtl/sss_unroll.sv
module sss_unroll
    import gfp_sss_pkg::*;
#(
    parameter int       TAP = SSS_TAP,
    parameter int       W   = SSS_OCTET,
    parameter sss_dir_e DIR = SSS_SCRAMBLE
) (
    input  logic [TAP-1:0] hist_in,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   dout,
    output logic [TAP-1:0] hist_out
);

    logic [TAP-1:0] chain [W+1];

    assign chain[0] = hist_in;

    for (genvar k = 0; k < W; k++) begin : g_bit
        localparam int B = W - 1 - k;
        logic obit;
        logic fbit;
        assign obit = din[B] ^ chain[k][TAP-1];
        if (DIR == SSS_DESCRAMBLE) begin : g_desc
            assign fbit = din[B];
        end else begin : g_scr
            assign fbit = obit;
        end
        assign dout[B]    = obit;
        assign chain[k+1] = {chain[k][TAP-2:0], fbit};
    end

    assign hist_out = chain[W];

endmodule

// File: rtl/sss_lane.sv
module sss_lane
    import gfp_sss_pkg::*;
#(
    parameter int       TAP = SSS_TAP,
    parameter int       W   = SSS_OCTET,
    parameter sss_dir_e DIR = SSS_SCRAMBLE
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   din,
    input  logic           din_valid,
    input  logic           active,
    output logic [W-1:0]   dout,
    output logic           dout_valid,
    output logic [TAP-1:0] hist
);

    logic [TAP-1:0] hist_q;
    logic [TAP-1:0] hist_nx;
    logic [W-1:0]   mix;
    logic [W-1:0]   dout_q;
    logic           vld_q;
    logic           take;

    sss_unroll #(.TAP(TAP), .W(W), .DIR(DIR)) u_unroll (
        .hist_in  (hist_q),
        .din      (din),
        .dout     (mix),
        .hist_out (hist_nx)
    );

    assign take = din_valid && active;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            dout_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= din_valid;
            if (din_valid) begin
                dout_q <= take ? mix : din;
            end
            if (take) begin
                hist_q <= hist_nx;
            end
        end
    end

    assign dout       = dout_q;
    assign dout_valid = vld_q;
    assign hist       = hist_q;

endmodule

// File: rtl/gfp_payload_scrambler.sv
module gfp_payload_scrambler
    import gfp_sss_pkg::*;
#(
    parameter int TAP = SSS_TAP,
    parameter int W   = SSS_OCTET
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] tx_data,
    input  logic         tx_valid,
    input  logic         tx_payload,
    output logic [W-1:0] tx_out,
    output logic         tx_out_valid,
    input  logic [W-1:0] rx_data,
    input  logic         rx_valid,
    input  logic         rx_payload,
    input  logic         rx_in_sync,
    output logic [W-1:0] rx_out,
    output logic         rx_out_valid
);

    logic [TAP-1:0] tx_hist;
    logic [TAP-1:0] rx_hist;
    logic           rx_active;

    assign rx_active = rx_payload && rx_in_sync;

    sss_lane #(.TAP(TAP), .W(W), .DIR(SSS_SCRAMBLE)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .din        (tx_data),
        .din_valid  (tx_valid),
        .active     (tx_payload),
        .dout       (tx_out),
        .dout_valid (tx_out_valid),
        .hist       (tx_hist)
    );

    sss_lane #(.TAP(TAP), .W(W), .DIR(SSS_DESCRAMBLE)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .din        (rx_data),
        .din_valid  (rx_valid),
        .active     (rx_active),
        .dout       (rx_out),
        .dout_valid (rx_out_valid),
        .hist       (rx_hist)
    );

endmodule

// File: rtl/gfp_payload_scrambler_chk.sv
module gfp_payload_scrambler_chk #(
    parameter int TAP = 43,
    parameter int W   = 8
) (
    input logic           clk,
    input logic           rst,
    input logic [W-1:0]   tx_data,
    input logic           tx_valid,
    input logic           tx_payload,
    input logic [W-1:0]   tx_out,
    input logic           tx_out_valid,
    input logic [TAP-1:0] tx_hist,
    input logic [W-1:0]   rx_data,
    input logic           rx_valid,
    input logic           rx_payload,
    input logic           rx_in_sync,
    input logic [W-1:0]   rx_out,
    input logic           rx_out_valid,
    input logic [TAP-1:0] rx_hist
);

    a_r6_tx_latency: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> tx_out_valid);
    a_r6_rx_idle: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !rx_out_valid);
    a_r1_tx_hist_tracks_out: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_payload) |=> (tx_hist[W-1:0] == tx_out));
    a_r2_rx_hist_tracks_in: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_payload && rx_in_sync) |=> (rx_hist[W-1:0] == $past(rx_data)));
    a_r3_tx_header_bypass: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_payload) |=> (tx_out == $past(tx_data)) && $stable(tx_hist));
    a_r4_tx_gap_hold: assert property (@(posedge clk) disable iff (rst)
        !tx_valid |=> $stable(tx_hist) && $stable(tx_out));
    a_r5_rx_unsync_bypass: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_in_sync) |=> (rx_out == $past(rx_data)) && $stable(rx_hist));
    a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> (tx_hist == '0) && (rx_hist == '0) && !tx_out_valid && !rx_out_valid);

endmodule

bind gfp_payload_scrambler gfp_payload_scrambler_chk #(.TAP(TAP), .W(W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_data      (tx_data),
    .tx_valid     (tx_valid),
    .tx_payload   (tx_payload),
    .tx_out       (tx_out),
    .tx_out_valid (tx_out_valid),
    .tx_hist      (tx_hist),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_payload   (rx_payload),
    .rx_in_sync   (rx_in_sync),
    .rx_out       (rx_out),
    .rx_out_valid (rx_out_valid),
    .rx_hist      (rx_hist)
);

// File: tb/gfp_payload_scrambler_bench.sv
`timescale 1ns/1ps
module gfp_payload_scrambler_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_payload = 1'b0;
    logic [7:0] tx_out;
    logic       tx_out_valid;
    logic [7:0] rx_data = '0;
    logic       rx_valid = 1'b0;
    logic       rx_payload = 1'b0;
    logic       rx_in_sync = 1'b0;
    logic [7:0] rx_out;
    logic       rx_out_valid;

    always #2.5 clk = ~clk;

    gfp_payload_scrambler u_gfp_payload_scrambler (
        .clk (clk), .rst (rst),
        .tx_data (tx_data), .tx_valid (tx_valid), .tx_payload (tx_payload),
        .tx_out (tx_out), .tx_out_valid (tx_out_valid),
        .rx_data (rx_data), .rx_valid (rx_valid), .rx_payload (rx_payload),
        .rx_in_sync (rx_in_sync), .rx_out (rx_out), .rx_out_valid (rx_out_valid)
    );

    int applied = 0;
    int errors  = 0;
    bit done    = 0;

    logic [42:0] m_tx = '0;
    logic [42:0] m_rx = '0;

    logic        q_tv [$];
    logic [7:0]  q_td [$];
    string       q_tt [$];
    logic        q_rv [$];
    logic [7:0]  q_rd [$];
    string       q_rt [$];

    function automatic logic [7:0] model(inout logic [42:0] h, input logic [7:0] d, input bit desc);
        logic [7:0] o;
        for (int i = 7; i >= 0; i--) begin
            o[i] = d[i] ^ h[42];
            h = {h[41:0], desc ? d[i] : o[i]};
        end
        return o;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        applied++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] td, input bit tv, input bit tp,
                        input logic [7:0] rd_in, input bit rv_in, input bit rp_in, input bit rs_in,
                        input bit loopb, input string ttag, input string rtag);
        logic [7:0] et, er, rd;
        bit rv, rp, rs;
        @(negedge clk);
        et = (tv && tp) ? model(m_tx, td, 1'b0) : td;
        rd = loopb ? et : rd_in;
        rv = loopb ? tv : rv_in;
        rp = loopb ? tp : rp_in;
        rs = loopb ? 1'b1 : rs_in;
        er = (rv && rp && rs) ? model(m_rx, rd, 1'b1) : rd;
        if (loopb) er = td;
        tx_data = td; tx_valid = tv; tx_payload = tp;
        rx_data = rd; rx_valid = rv; rx_payload = rp; rx_in_sync = rs;
        q_tv.push_back(tv); q_td.push_back(et); q_tt.push_back(ttag);
        q_rv.push_back(rv); q_rd.push_back(er); q_rt.push_back(rtag);
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #1;
        if (q_tv.size() > 0) begin
            logic v; logic [7:0] d; string t;
            v = q_tv.pop_front(); d = q_td.pop_front(); t = q_tt.pop_front();
            check({t, " tx valid (R6)"}, {7'd0, tx_out_valid}, {7'd0, v});
            if (v) check({t, " tx data"}, tx_out, d);
        end
        if (q_rv.size() > 0) begin
            logic v; logic [7:0] d; string t;
            v = q_rv.pop_front(); d = q_rd.pop_front(); t = q_rt.pop_front();
            check({t, " rx valid (R6)"}, {7'd0, rx_out_valid}, {7'd0, v});
            if (v) check({t, " rx data"}, rx_out, d);
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: reset state
        check("R7 reset tx_out_valid", {7'd0, tx_out_valid}, 8'd0);
        check("R7 reset rx_out_valid", {7'd0, rx_out_valid}, 8'd0);
        check("R7 reset tx_out", tx_out, 8'd0);

        // R7: first five payload octets after reset pass unchanged (zero history)
        for (int i = 0; i < 5; i++) begin
            logic [7:0] d;
            d = 8'(i * 37 + 11);
            step(d, 1, 1, 8'h00, 0, 0, 0, 1, "R7", "R8");
            @(posedge clk); #1;
            check("R7 first-bits tx passthrough", tx_out, d);
        end
        // R1/R8: long looped payload
        for (int i = 0; i < 40; i++)
            step(8'($urandom), 1, 1, 8'h00, 0, 0, 0, 1, "R1", "R8");
        // R3: header octets bypass
        for (int i = 0; i < 4; i++)
            step(8'($urandom), 1, 0, 8'h00, 0, 0, 0, 1, "R3", "R3");
        // R6: idle cycles
        for (int i = 0; i < 3; i++)
            step(8'($urandom), 0, 0, 8'h00, 0, 0, 0, 1, "R6", "R6");
        // R4: next frame continues the history
        for (int i = 0; i < 30; i++)
            step(8'($urandom), 1, 1, 8'h00, 0, 0, 0, 1, "R4", "R4");
        // R4/R6: random gaps and headers between payload octets
        for (int i = 0; i < 60; i++) begin
            bit v, p;
            v = ($urandom % 3) != 0;
            p = ($urandom % 4) != 0;
            step(8'($urandom), v, p, 8'h00, 0, 0, 0, 1, "R4", "R4");
        end
        // R5: receive out of sync, payload gate high
        for (int i = 0; i < 12; i++)
            step(8'h00, 0, 0, 8'($urandom), 1, 1, 0, 0, "R6", "R5");
        // R2: receive back in sync on arbitrary data
        for (int i = 0; i < 30; i++)
            step(8'h00, 0, 0, 8'($urandom), 1, 1, 1, 0, "R6", "R2");
        // R2/R4: receive gaps and headers
        for (int i = 0; i < 40; i++) begin
            bit v, p;
            v = ($urandom % 3) != 0;
            p = ($urandom % 4) != 0;
            step(8'h00, 0, 0, 8'($urandom), v, p, 1, 0, "R6", "R2");
        end
        step(8'h00, 0, 0, 8'h00, 0, 0, 0, 0, "R6", "R6");
        repeat (4) @(negedge clk);
        check("R6 scoreboard drained", 8'(q_tv.size() + q_rv.size()), 8'd0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

endmodule